// File: doc/BRIEF.md
# Inbound Doorbell Receiver and Responder

This block terminates inbound doorbell requests coming from the transport side. Each request carries a source ID, a destination ID, a transaction ID and a 16-bit info word. The block answers every request itself with a response descriptor. When the receive queue has room, the request is queued and answered DONE. When the queue is full, the request is dropped and answered RETRY, so that the sender tries again later.

Software sees the queue through a small register window. One register returns the number of waiting messages. A second register pops the oldest message on each read. The remaining registers hold the interrupt status bits and the interrupt enable bits. A single interrupt line is shared between receive arrivals and transmit-completion events, and separate status bits tell the two causes apart.

The response path is a two-state machine. In state IDLE the block accepts one request per cycle. Accepting a request (transition IDLE→RESP) latches the response descriptor. In state RESP the descriptor is presented with valid. The handshake completing (transition RESP→IDLE) returns the machine to IDLE. While in RESP, inbound requests are held off by backpressure.

Top module: `dbell_rx_responder`

## Requirements
- R1: `req_ready` is high exactly when no response is pending, that is in state IDLE. While `rsp_valid` is high, `req_ready` is low and no request is taken.
- R2: A request accepted while the queue holds fewer than DEPTH messages is appended to the queue. On the next cycle its response carries status DONE, encoded as `rsp_status` = 0.
- R3: A request accepted while the queue holds DEPTH messages is not queued and the count does not rise. On the next cycle its response carries status RETRY, encoded as `rsp_status` = 1. The fullness test uses the count from before any pop in that same cycle.
- R4: The response descriptor has `rsp_ftype` = 13 and echoes the request's transaction ID. Its `rsp_src_id` is the request's destination ID and its `rsp_dst_id` is the request's source ID.
- R5: Once raised, `rsp_valid` and all descriptor fields stay unchanged until a cycle in which `rsp_ready` is high. On that edge the block returns to IDLE.
- R6: A read of register address 0 returns the number of queued messages in the low bits.
- R7: A read of register address 1 returns the oldest message packed as {src_id[31:24], tid[23:16], info[15:0]} and removes it from the queue. When the queue is empty, the read returns 0 and changes nothing.
- R8: Interrupt status bit 0 (receive) is set on every accepted request, whether DONE or RETRY. It is cleared on an edge where no request is accepted and the queue count was zero before that edge.
- R9: Register address 2 reads {tx status bit 1, rx status bit 0}. Writing 1 to a bit clears it, unless an event sets it on the same edge. Bit 1 is set by a pulse on `tx_cpl_evt`.
- R10: Register address 3 holds the enable bits [1:0], which reset to 0. `irq` is high when any status bit is set and its enable bit is also set.
- R11: After reset the queue is empty, no response is pending, all status and enable bits are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Inbound doorbell request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_src_id | input | ID_W | Requester ID |
| req_dst_id | input | ID_W | Target ID of the request |
| req_tid | input | TID_W | Transaction ID |
| req_info | input | INFO_W | Doorbell info payload |
| rsp_valid | output | 1 | Response descriptor present |
| rsp_ready | input | 1 | Transport side takes the response |
| rsp_ftype | output | 4 | Message type of the response, always 13 |
| rsp_src_id | output | ID_W | Response source (request's destination) |
| rsp_dst_id | output | ID_W | Response destination (request's source) |
| rsp_tid | output | TID_W | Echoed transaction ID |
| rsp_status | output | 1 | 0 = DONE, 1 = RETRY |
| tx_cpl_evt | input | 1 | Pulse from the outbound path: a completion arrived |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at address 1 pops) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| irq | output | 1 | Shared interrupt line |

## Verification
The bench fills the queue to exactly DEPTH and then sends more requests. A block with an off-by-one fullness test would either answer DONE while dropping the message, or RETRY while the queue still had room. Responses are stalled for several cycles to catch descriptors that change, and requests arriving during a pending response that get taken anyway. The bench pops the queue dry, plus one extra read, and then watches the receive status bit: a design that clears it too early, never clears it, or pops from an empty queue diverges from the model. Write-1-to-clear is exercised on both bits while events keep arriving. A long randomised phase lines up pops, arrivals and clears on the same edge.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    typedef enum logic [0:0] {
        RSP_DONE  = 1'b0,
        RSP_RETRY = 1'b1
    } rsp_status_e;

    localparam logic [3:0] FTYPE_DBELL_RSP = 4'd13;

    localparam logic [1:0] ADDR_COUNT    = 2'd0;
    localparam logic [1:0] ADDR_POP      = 2'd1;
    localparam logic [1:0] ADDR_IRQ_STAT = 2'd2;
    localparam logic [1:0] ADDR_IRQ_EN   = 2'd3;
endpackage

// File: rtl/dbell_fifo.sv
module dbell_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rptr];
endmodule

// File: rtl/dbell_resp_fsm.sv
module dbell_resp_fsm
    import dbell_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int TID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_src_id,
    input  logic [ID_W-1:0]  req_dst_id,
    input  logic [TID_W-1:0] req_tid,
    input  logic             queue_full,
    input  logic             rsp_ready,
    output logic             req_ready,
    output logic             accept,
    output logic             push,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_src_id,
    output logic [ID_W-1:0]  rsp_dst_id,
    output logic [TID_W-1:0] rsp_tid,
    output rsp_status_e      rsp_status
);
    rsp_state_e state, state_nx;

    // State register with latched descriptor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rsp_src_id <= '0;
            rsp_dst_id <= '0;
            rsp_tid    <= '0;
            rsp_status <= RSP_DONE;
        end else begin
            state <= state_nx;
            if (accept) begin
                rsp_src_id <= req_dst_id;
                rsp_dst_id <= req_src_id;
                rsp_tid    <= req_tid;
                rsp_status <= queue_full ? RSP_RETRY : RSP_DONE;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        accept    = 1'b0;
        push      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept   = 1'b1;
                    push     = !queue_full;
                    state_nx = ST_RESP;
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) state_nx = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_arrival,
    input  logic       queue_empty,
    input  logic       tx_evt,
    input  logic       stat_wr,
    input  logic       en_wr,
    input  logic [1:0] wbits,
    output logic [1:0] stat,
    output logic [1:0] en,
    output logic       irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            if (rx_arrival)                       stat[0] <= 1'b1;
            else if ((stat_wr && wbits[0]) || queue_empty) stat[0] <= 1'b0;

            if (tx_evt)                    stat[1] <= 1'b1;
            else if (stat_wr && wbits[1])  stat[1] <= 1'b0;

            if (en_wr) en <= wbits;
        end
    end

    assign irq = |(stat & en);
endmodule

// File: rtl/dbell_rx_responder.sv
module dbell_rx_responder
    import dbell_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int TID_W  = 8,
    parameter int INFO_W = 16,
    parameter int DEPTH  = 8,
    localparam int EW    = ID_W + TID_W + INFO_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_src_id,
    input  logic [ID_W-1:0]   req_dst_id,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [INFO_W-1:0] req_info,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [3:0]        rsp_ftype,
    output logic [ID_W-1:0]   rsp_src_id,
    output logic [ID_W-1:0]   rsp_dst_id,
    output logic [TID_W-1:0]  rsp_tid,
    output logic              rsp_status,
    input  logic              tx_cpl_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic          accept, push, pop, queue_full, queue_empty;
    logic [CW-1:0] fifo_count;
    logic [EW-1:0] head;
    logic [1:0]    irq_stat, irq_en;
    rsp_status_e   status_e;

    assign queue_full  = (fifo_count == CW'(DEPTH));
    assign queue_empty = (fifo_count == '0);
    assign pop         = reg_rd && (reg_addr == ADDR_POP) && !queue_empty;
    assign rsp_ftype   = FTYPE_DBELL_RSP;
    assign rsp_status  = status_e;

    dbell_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata({req_src_id, req_tid, req_info}),
        .pop(pop), .rdata(head), .count(fifo_count)
    );

    dbell_resp_fsm #(.ID_W(ID_W), .TID_W(TID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src_id(req_src_id),
        .req_dst_id(req_dst_id), .req_tid(req_tid),
        .queue_full(queue_full), .rsp_ready(rsp_ready),
        .req_ready(req_ready), .accept(accept), .push(push),
        .rsp_valid(rsp_valid), .rsp_src_id(rsp_src_id),
        .rsp_dst_id(rsp_dst_id), .rsp_tid(rsp_tid), .rsp_status(status_e)
    );

    dbell_irq_regs u_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_arrival(accept), .queue_empty(queue_empty), .tx_evt(tx_cpl_evt),
        .stat_wr(reg_wr && reg_addr == ADDR_IRQ_STAT),
        .en_wr(reg_wr && reg_addr == ADDR_IRQ_EN),
        .wbits(reg_wdata[1:0]),
        .stat(irq_stat), .en(irq_en), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_COUNT:    reg_rdata[CW-1:0] = fifo_count;
            ADDR_POP:      if (!queue_empty) reg_rdata[EW-1:0] = head;
            ADDR_IRQ_STAT: reg_rdata[1:0] = irq_stat;
            ADDR_IRQ_EN:   reg_rdata[1:0] = irq_en;
        endcase
    end
endmodule

// File: rtl/dbell_rx_chk.sv
module dbell_rx_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int TID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [TID_W-1:0] rsp_tid,
    input logic             rsp_status,
    input logic [CW-1:0]    fifo_count,
    input logic [1:0]       irq_stat
);
    AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_DONE_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && fifo_count < CW'(DEPTH)) |=> (rsp_valid && !rsp_status && fifo_count != '0)); // R2
    AST_RETRY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && fifo_count == CW'(DEPTH)) |=> (rsp_valid && rsp_status)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R3
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tid) && $stable(rsp_status))); // R5
    AST_RX_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> irq_stat[0]); // R8
    AST_RX_STAT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && !(req_valid && req_ready)) |=> !irq_stat[0]); // R8
endmodule

bind dbell_rx_responder dbell_rx_chk #(.DEPTH(DEPTH), .CW(CW), .TID_W(TID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tid(rsp_tid),
    .rsp_status(rsp_status), .fifo_count(fifo_count), .irq_stat(irq_stat)
);

// File: tb/sim_dbell_rx_responder.sv
module sim_dbell_rx_responder;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, rsp_ready = 1'b1, tx_cpl_evt = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  req_src_id = '0, req_dst_id = '0, req_tid = '0;
    logic [15:0] req_info = '0;
    logic        req_ready, rsp_valid, rsp_status, irq;
    logic [3:0]  rsp_ftype;
    logic [7:0]  rsp_src_id, rsp_dst_id, rsp_tid;
    logic [31:0] reg_rdata;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    dbell_rx_responder #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_id(req_src_id), .req_dst_id(req_dst_id), .req_tid(req_tid),
        .req_info(req_info), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_ftype(rsp_ftype), .rsp_src_id(rsp_src_id), .rsp_dst_id(rsp_dst_id),
        .rsp_tid(rsp_tid), .rsp_status(rsp_status), .tx_cpl_evt(tx_cpl_evt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] mq[$];
    bit          m_pend, m_stat, m_rx, m_tx;
    bit [1:0]    m_en;
    logic [7:0]  m_src, m_dst, m_tid;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_pend = 0; m_stat = 0; m_rx = 0; m_tx = 0; m_en = 0;
            m_src = 0; m_dst = 0; m_tid = 0;
        end else begin
            automatic bit arr  = req_valid && !m_pend;
            automatic int sz   = mq.size();
            automatic bit full = (sz == DEPTH);
            automatic bit w1c  = reg_wr && reg_addr == 2'd2;
            automatic bit nrx  = arr ? 1'b1 : ((w1c && reg_wdata[0]) || sz == 0) ? 1'b0 : m_rx;
            automatic bit ntx  = tx_cpl_evt ? 1'b1 : (w1c && reg_wdata[1]) ? 1'b0 : m_tx;
            m_rx = nrx;
            m_tx = ntx;
            if (reg_wr && reg_addr == 2'd3) m_en = reg_wdata[1:0];
            if (reg_rd && reg_addr == 2'd1 && sz > 0) void'(mq.pop_front());
            if (m_pend && rsp_ready) m_pend = 0;
            if (arr) begin
                m_pend = 1; m_src = req_dst_id; m_dst = req_src_id; m_tid = req_tid;
                m_stat = full;
                if (!full) mq.push_back({req_src_id, req_tid, req_info});
            end
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
        end
    endtask

    // Compare on every clock, half a period after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1", "req_ready", 32'(req_ready), 32'(!m_pend));
            check("R5", "rsp_valid", 32'(rsp_valid), 32'(m_pend));
            if (m_pend) begin
                check("R4", "rsp_ftype", 32'(rsp_ftype), 32'd13);
                check("R4", "rsp_src_id", 32'(rsp_src_id), 32'(m_src));
                check("R4", "rsp_dst_id", 32'(rsp_dst_id), 32'(m_dst));
                check("R4", "rsp_tid", 32'(rsp_tid), 32'(m_tid));
                check("R2 R3", "rsp_status", 32'(rsp_status), 32'(m_stat));
            end
            check("R10", "irq", 32'(irq), 32'(|({m_tx, m_rx} & m_en)));
            if (reg_rd) begin
                unique case (reg_addr)
                    2'd0: check("R6", "count", reg_rdata, 32'(mq.size()));
                    2'd1: check("R7", "pop data", reg_rdata, mq.size() > 0 ? mq[0] : 32'h0);
                    2'd2: check("R8 R9", "irq status", reg_rdata, {30'h0, m_tx, m_rx});
                    2'd3: check("R10", "irq enable", reg_rdata, {30'h0, m_en});
                endcase
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send(input logic [7:0] s, input logic [7:0] d, input logic [7:0] t, input logic [15:0] inf);
        bit acc;
        req_valid = 1; req_src_id = s; req_dst_id = d; req_tid = t; req_info = inf;
        do begin
            @(negedge clk); acc = req_ready;
            step();
        end while (!acc);
        req_valid = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_rd = 1; reg_addr = a; step(); reg_rd = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v; step(); reg_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        // R11: reset state
        @(negedge clk);
        check("R11", "reset req_ready", 32'(req_ready), 32'd1);
        check("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R11", "reset irq", 32'(irq), 32'd0);
        reg_rd = 1; reg_addr = 2'd0; #1;
        check("R11", "reset count", reg_rdata, 32'd0);
        reg_addr = 2'd2; #1;
        check("R11", "reset status", reg_rdata, 32'd0);
        reg_rd = 0;
        @(posedge clk); #1;
        rst_n = 1;
        step(2);

        // R5: response stalled by transport side
        rsp_ready = 0;
        send(8'h11, 8'h22, 8'h01, 16'hA001);
        req_valid = 1; req_tid = 8'h7F;        // must be held off (R1)
        step(4);
        req_valid = 0;
        rsp_ready = 1;
        step(2);

        // R2 / R3: fill to DEPTH, then overflow with RETRY
        for (int i = 0; i < DEPTH + 2; i++)
            send(8'h30 + 8'(i), 8'h40, 8'h10 + 8'(i), 16'hB000 + 16'(i));
        step(2);
        rd(2'd0);                 // R6
        rd(2'd2);                 // R8
        wr(2'd3, 32'h1);          // R10 enable rx
        rd(2'd3);
        step(1);

        // R7: drain in order plus an empty pop
        for (int i = 0; i < DEPTH + 1; i++) rd(2'd1);
        rd(2'd0);
        rd(2'd2);                 // R8 self-clear
        step(1);
        rd(2'd2);

        // R9: tx event and write-1-to-clear
        wr(2'd3, 32'h3);
        tx_cpl_evt = 1; step(); tx_cpl_evt = 0;
        rd(2'd2);
        wr(2'd2, 32'h2);
        rd(2'd2);
        send(8'h55, 8'h66, 8'h77, 16'hCAFE);
        wr(2'd2, 32'h1);          // clear rx while queue non-empty
        rd(2'd2);
        rd(2'd1);

        // Mixed random phase
        for (int c = 0; c < 3000; c++) begin
            req_valid  = ($urandom_range(0, 2) != 0);
            req_src_id = 8'($urandom); req_dst_id = 8'($urandom);
            req_tid    = 8'($urandom); req_info = 16'($urandom);
            rsp_ready  = ($urandom_range(0, 3) != 0);
            tx_cpl_evt = ($urandom_range(0, 15) == 0);
            reg_addr   = 2'($urandom);
            reg_rd     = ($urandom_range(0, 2) == 0);
            reg_wr     = !reg_rd && ($urandom_range(0, 4) == 0);
            reg_wdata  = $urandom;
            step();
        end
        req_valid = 0; reg_rd = 0; reg_wr = 0; tx_cpl_evt = 0; rsp_ready = 1;
        step(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule